// File: doc/BRIEF.md
# AC-link Status Frame Serializer

This block is the codec-side transmitter of the serial status frame that a codec returns to its link controller. Each rising edge of the frame strobe starts one frame. The block then shifts out, one bit per bit clock and most significant bit first, a 16-bit tag slot and two 20-bit status slots. Every slot after those two is driven as zeros.

The first tag bit reports whether the codec is operational. This bit stays low for a parameterised number of frames after reset. The next two tag bits mark the two status slots as carrying data. These two bits are set only when a register read has been requested and the frame is marked ready.

An upstream command decoder posts reads as a one-cycle request with a 7-bit register index. The register storage sits outside the block and is read through a combinational address/data port. In a responding frame, slot 1 echoes the index and slot 2 carries the 16-bit word read at that index.

Top module: `aclink_status_tx`

## Requirements
- R1: After reset the serial output is 0 and the read address port is 0 until the first frame strobe rises.
- R2: On the first clock edge that samples the strobe high after it was low, bit 0 of the frame (tag bit 15) is launched. Each later edge launches the next bit, most significant bit first. The frame is 16 tag bits followed by 20-bit slots.
- R3: Tag bit 15 (frame bit 0) is 0 in the first READY_FRAMES frames after reset and 1 in every frame after those.
- R4: Tag bits 14 and 13 (frame bits 1 and 2) are both 1 in a ready frame that answers a pending read. They are both 0 in every other frame.
- R5: Tag bits 12 down to 0 (frame bits 3 to 15) are always 0.
- R6: In a responding frame, slot 1 carries the requested index in bits 18 to 12, and its other bits are 0.
- R7: In a responding frame, slot 2 carries, in bits 19 to 4, the word read at the requested index (sampled on the frame's first edge). Bits 3 to 0 of slot 2 are 0.
- R8: Slots 3 to 12, any slot-1 or slot-2 contents of a frame that does not respond, and the output between frames are all 0.
- R9: A read posted while frames are not yet ready stays pending. It is answered by the first ready frame, and each read is answered exactly once.
- R10: A second read posted before the answering frame starts replaces the first. The read address changes only on a posted read.
- R11: Only a low-to-high strobe transition starts a frame. A strobe held high past the frame end does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame strobe; a rising edge starts a frame |
| req_valid | input | 1 | One-cycle register read request |
| req_index | input | IDX_BITS | Register index of the read request |
| rd_addr | output | IDX_BITS | Address to the external register storage |
| rd_data | input | DATA_BITS | Combinational read data for rd_addr |
| sdata | output | 1 | Serial status frame, launched on the rising clock edge |

## Verification
The bench sweeps a read of every one of the 128 register indices and decodes each full 256-bit frame into ready bit, tag pair, low tags, both status slots and tail. Because the external register model returns a distinct word for each index, any bit-order or alignment fault shows up as a slot mismatch. Reads posted before readiness, two reads posted back to back, and a read posted in the middle of a frame separate the three cases: a held request, a replaced index, and an answer that lands one frame late. A strobe held far beyond the frame length separates edge-triggered from level-triggered frame starts.

// File: rtl/aclink_stx_pkg.sv
package aclink_stx_pkg;
   localparam int TAG_BITS   = 16;
   localparam int SLOT_BITS  = 20;
   localparam int SLOT_COUNT = 12;
   localparam int IDX_BITS   = 7;
   localparam int DATA_BITS  = 16;
   localparam int FRAME_BITS = TAG_BITS + SLOT_COUNT * SLOT_BITS;

   typedef struct packed {
      logic ready;
      logic cmd_slot;
      logic data_slot;
   } tag_head_t;
endpackage

// File: rtl/aclink_stx_frame.sv
module aclink_stx_frame #(
   parameter int READY_FRAMES = 3
) (
   input  logic bitclk,
   input  logic rst_n,
   input  logic sync,
   output logic frame_start,
   output logic ready_next
);
   logic sync_q;

   always_ff @(posedge bitclk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync;
   end

   assign frame_start = sync & ~sync_q;

   generate
      if (READY_FRAMES == 0) begin : g_no_hold
         assign ready_next = 1'b1;
      end else begin : g_hold
         localparam int CNT_W = $clog2(READY_FRAMES + 1);
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(READY_FRAMES);
         logic [CNT_W-1:0] seen;

         always_ff @(posedge bitclk or negedge rst_n) begin
            if (!rst_n)
               seen <= '0;
            else if (frame_start && seen != LIMIT)
               seen <= seen + 1'b1;
         end

         assign ready_next = (seen == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/aclink_stx_resp.sv
module aclink_stx_resp #(
   parameter int IDX_BITS  = 7,
   parameter int DATA_BITS = 16,
   parameter int SLOT_BITS = 20
) (
   input  logic                 bitclk,
   input  logic                 rst_n,
   input  logic                 frame_start,
   input  logic                 ready_next,
   input  logic                 req_valid,
   input  logic [IDX_BITS-1:0]  req_index,
   output logic [IDX_BITS-1:0]  rd_addr,
   input  logic [DATA_BITS-1:0] rd_data,
   output logic                 resp_go,
   output logic [SLOT_BITS-1:0] cmd_word,
   output logic [SLOT_BITS-1:0] data_word
);
   localparam int CMD_PAD  = SLOT_BITS - 1 - IDX_BITS;
   localparam int DATA_PAD = SLOT_BITS - DATA_BITS;

   logic                pending;
   logic [IDX_BITS-1:0] idx_q;
   logic                consume;

   assign consume = frame_start & ready_next;

   always_ff @(posedge bitclk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         idx_q   <= '0;
      end else if (consume) begin
         pending <= req_valid;
         if (req_valid) idx_q <= req_index;
      end else if (req_valid) begin
         pending <= 1'b1;
         idx_q   <= req_index;
      end
   end

   assign rd_addr = idx_q;
   assign resp_go = pending & ready_next;

   generate
      if (CMD_PAD > 0) begin : g_cmd_pad
         assign cmd_word = resp_go ? {1'b0, idx_q, {CMD_PAD{1'b0}}} : '0;
      end else begin : g_cmd_flush
         assign cmd_word = resp_go ? {1'b0, idx_q} : '0;
      end
      if (DATA_PAD > 0) begin : g_data_pad
         assign data_word = resp_go ? {rd_data, {DATA_PAD{1'b0}}} : '0;
      end else begin : g_data_flush
         assign data_word = resp_go ? rd_data : '0;
      end
   endgenerate
endmodule

// File: rtl/aclink_stx_shift.sv
module aclink_stx_shift #(
   parameter int HEAD_BITS = 56
) (
   input  logic                 bitclk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [HEAD_BITS-1:0] head,
   output logic                 sdata
);
   logic [HEAD_BITS-1:0] sh;

   always_ff @(posedge bitclk or negedge rst_n) begin
      if (!rst_n)    sh <= '0;
      else if (load) sh <= head;
      else           sh <= {sh[HEAD_BITS-2:0], 1'b0};
   end

   assign sdata = sh[HEAD_BITS-1];
endmodule

// File: rtl/aclink_status_tx.sv
module aclink_status_tx
   import aclink_stx_pkg::*;
#(
   parameter int READY_FRAMES = 3,
   parameter int IDX_BITS     = aclink_stx_pkg::IDX_BITS,
   parameter int DATA_BITS    = aclink_stx_pkg::DATA_BITS,
   parameter int SLOT_BITS    = aclink_stx_pkg::SLOT_BITS,
   parameter int TAG_BITS     = aclink_stx_pkg::TAG_BITS
) (
   input  logic                 bitclk,
   input  logic                 rst_n,
   input  logic                 sync,
   input  logic                 req_valid,
   input  logic [IDX_BITS-1:0]  req_index,
   output logic [IDX_BITS-1:0]  rd_addr,
   input  logic [DATA_BITS-1:0] rd_data,
   output logic                 sdata
);
   localparam int TAG_PAD   = TAG_BITS - 3;
   localparam int HEAD_BITS = TAG_BITS + 2 * SLOT_BITS;

   if (TAG_BITS < 4) begin : g_bad_tag
      $error("TAG_BITS must leave room for ready and two slot tags");
   end
   if (IDX_BITS > SLOT_BITS - 1) begin : g_bad_idx
      $error("IDX_BITS must fit below the top bit of a slot");
   end
   if (DATA_BITS > SLOT_BITS) begin : g_bad_data
      $error("DATA_BITS must not exceed SLOT_BITS");
   end
   if (READY_FRAMES < 0) begin : g_bad_ready
      $error("READY_FRAMES must be non-negative");
   end

   logic                 frame_start;
   logic                 ready_next;
   logic                 resp_go;
   logic [SLOT_BITS-1:0] cmd_word;
   logic [SLOT_BITS-1:0] data_word;
   tag_head_t            tag_head;
   logic [HEAD_BITS-1:0] head;

   aclink_stx_frame #(.READY_FRAMES(READY_FRAMES)) u_frame (
      .bitclk      (bitclk),
      .rst_n       (rst_n),
      .sync        (sync),
      .frame_start (frame_start),
      .ready_next  (ready_next)
   );

   aclink_stx_resp #(
      .IDX_BITS  (IDX_BITS),
      .DATA_BITS (DATA_BITS),
      .SLOT_BITS (SLOT_BITS)
   ) u_resp (
      .bitclk      (bitclk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .ready_next  (ready_next),
      .req_valid   (req_valid),
      .req_index   (req_index),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .resp_go     (resp_go),
      .cmd_word    (cmd_word),
      .data_word   (data_word)
   );

   assign tag_head.ready     = ready_next;
   assign tag_head.cmd_slot  = resp_go;
   assign tag_head.data_slot = resp_go;
   assign head = {tag_head, {TAG_PAD{1'b0}}, cmd_word, data_word};

   aclink_stx_shift #(.HEAD_BITS(HEAD_BITS)) u_shift (
      .bitclk (bitclk),
      .rst_n  (rst_n),
      .load   (frame_start),
      .head   (head),
      .sdata  (sdata)
   );
endmodule

// File: rtl/aclink_stx_checker.sv
module aclink_stx_checker #(
   parameter int READY_FRAMES = 3,
   parameter int IDX_BITS     = 7,
   parameter int TAG_BITS     = 16,
   parameter int HEAD_BITS    = 56
) (
   input logic                bitclk,
   input logic                rst_n,
   input logic                sync,
   input logic                req_valid,
   input logic [IDX_BITS-1:0] rd_addr,
   input logic                sdata
);
   localparam int POS_W = 12;
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             sync_seen;
   logic [POS_W-1:0] pos;
   logic [31:0]      frames;

   always_ff @(posedge bitclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_seen <= 1'b0;
         pos       <= POS_MAX;
         frames    <= '0;
      end else begin
         sync_seen <= sync;
         if (sync && !sync_seen) begin
            pos <= '0;
            if (frames != 32'hFFFF_FFFF) frames <= frames + 1;
         end else if (pos != POS_MAX) begin
            pos <= pos + 1'b1;
         end
      end
   end

   // R8: nothing beyond the two status slots, and nothing between frames
   assert_tail_zero_R8: assert property (@(posedge bitclk) disable iff (!rst_n)
      (pos >= POS_W'(HEAD_BITS)) |-> !sdata);

   // R5: low tag bits never set
   assert_low_tags_zero_R5: assert property (@(posedge bitclk) disable iff (!rst_n)
      (pos >= 3 && pos < POS_W'(TAG_BITS)) |-> !sdata);

   // R4: both slot tags agree
   assert_tag_pair_R4: assert property (@(posedge bitclk) disable iff (!rst_n)
      (pos == 2) |-> (sdata == $past(sdata)));

   // R3: ready flag follows the frame count since reset
   assert_ready_flag_R3: assert property (@(posedge bitclk) disable iff (!rst_n)
      (pos == 0) |-> (sdata == (frames > 32'(READY_FRAMES))));

   // R10: read address moves only on a posted read
   assert_addr_hold_R10: assert property (@(posedge bitclk) disable iff (!rst_n)
      !req_valid |=> $stable(rd_addr));
endmodule

bind aclink_status_tx aclink_stx_checker #(
   .READY_FRAMES (READY_FRAMES),
   .IDX_BITS     (IDX_BITS),
   .TAG_BITS     (TAG_BITS),
   .HEAD_BITS    (HEAD_BITS)
) u_chk (
   .bitclk    (bitclk),
   .rst_n     (rst_n),
   .sync      (sync),
   .req_valid (req_valid),
   .rd_addr   (rd_addr),
   .sdata     (sdata)
);

// File: tb/tb_aclink_status_tx.sv
module tb_aclink_status_tx;
   localparam int RF = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sync;
   logic        req_valid;
   logic [6:0]  req_index;
   logic [6:0]  rd_addr;
   logic [15:0] rd_data;
   logic        sdata;

   int total = 0;
   int fails = 0;
   int cyc   = 0;
   int fnum  = 0;

   always #4 clk = ~clk;

   function automatic logic [15:0] regval(input logic [6:0] a);
      return ({a, 9'h0} ^ (16'(a) * 16'd2053)) ^ 16'hC35A;
   endfunction

   assign rd_data = regval(rd_addr);

   aclink_status_tx #(.READY_FRAMES(RF)) dut (
      .bitclk    (clk),
      .rst_n     (rst_n),
      .sync      (sync),
      .req_valid (req_valid),
      .req_index (req_index),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .sdata     (sdata)
   );

   task automatic chk(input bit ok, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // Post one read request; output must stay idle meanwhile (R8)
   task automatic post(input logic [6:0] idx);
      req_valid = 1'b1;
      req_index = idx;
      @(negedge clk);
      req_valid = 1'b0;
      chk(sdata == 1'b0, "R8 idle between frames", 64'(sdata), 64'd0);
   endtask

   // Run one 256-bit frame; hold = strobe high cycles; mid = post a read at bit 100
   task automatic frame(input bit v, input logic [6:0] idx, input int hold,
                        input bit mid, input logic [6:0] mid_idx, input string note);
      logic [255:0] fr;
      bit           er;
      fnum++;
      er = (fnum > RF);
      sync = 1'b1;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         fr[255-i] = sdata;
         if (i == hold - 1) sync = 1'b0;
         if (mid && i == 100) begin
            req_valid = 1'b1;
            req_index = mid_idx;
         end
         if (mid && i == 101) req_valid = 1'b0;
      end
      // R2: bit 0 lands at fr[255]; MSB-first serial order is what the field slices below assume
      chk(fr[255] == er, {"R3 ready flag ", note}, 64'(fr[255]), 64'(er));
      chk(fr[254:253] == {v, v}, {"R4 slot tags ", note}, 64'(fr[254:253]), 64'({v, v}));
      chk(fr[252:240] == 13'd0, {"R5 low tags ", note}, 64'(fr[252:240]), 64'd0);
      chk(fr[239:220] == (v ? {1'b0, idx, 12'd0} : 20'd0), {"R6 slot1 ", note},
          64'(fr[239:220]), 64'(v ? {1'b0, idx, 12'd0} : 20'd0));
      chk(fr[219:200] == (v ? {regval(idx), 4'd0} : 20'd0), {"R7 slot2 ", note},
          64'(fr[219:200]), 64'(v ? {regval(idx), 4'd0} : 20'd0));
      chk(fr[199:0] == 200'd0, {"R8 slots 3-12 ", note}, 64'($countones(fr[199:0])), 64'd0);
      if (hold > 256) begin
         for (int j = 256; j < hold; j++) begin
            @(negedge clk);
            if (sdata) chk(1'b0, "R11 held strobe restarted", 64'(sdata), 64'd0);
         end
         chk(1'b1, "R11 held strobe", 64'd0, 64'd0);
         sync = 1'b0;
         @(negedge clk);
         chk(sdata == 1'b0, "R11 after held strobe", 64'(sdata), 64'd0);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      sync      = 1'b0;
      req_valid = 1'b0;
      req_index = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(sdata == 1'b0, "R1 idle after reset", 64'(sdata), 64'd0);
      end
      chk(rd_addr == 7'd0, "R1 read address after reset", 64'(rd_addr), 64'd0);

      // R9: read posted before readiness is held for the first ready frame
      post(7'd5);
      frame(1'b0, 7'd0, 16, 1'b0, 7'd0, "R9 not-ready 1");
      frame(1'b0, 7'd0, 16, 1'b0, 7'd0, "R9 not-ready 2");
      frame(1'b0, 7'd0, 16, 1'b0, 7'd0, "R9 not-ready 3");
      frame(1'b1, 7'd5, 16, 1'b0, 7'd0, "R9 first ready");
      frame(1'b0, 7'd0, 16, 1'b0, 7'd0, "R9 answered once");

      // R10: newer request replaces the older one
      post(7'd9);
      post(7'd17);
      frame(1'b1, 7'd17, 16, 1'b0, 7'd0, "R10 replaced");
      chk(rd_addr == 7'd17, "R10 read address", 64'(rd_addr), 64'd17);

      // request in the middle of a frame is answered by the next one
      frame(1'b0, 7'd0, 16, 1'b1, 7'd99, "R4 mid-frame post");
      frame(1'b1, 7'd99, 16, 1'b0, 7'd0, "R4 late answer");

      // R11: strobe held far past the frame end
      frame(1'b0, 7'd0, 300, 1'b0, 7'd0, "R11 held");
      frame(1'b0, 7'd0, 1, 1'b0, 7'd0, "R11 one-cycle strobe");

      // sweep every register index
      for (int k = 0; k < 128; k++) begin
         post(7'(k));
         frame(1'b1, 7'(k), 16, 1'b0, 7'd0, "R6 R7 sweep");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule